// File: doc/BRIEF.md
# Parcel Unpacker for 60-bit Instruction Words

This block sits between an instruction fetch stage and a decoder. It accepts 60-bit instruction words over a valid/ready handshake. It breaks each word into 15-bit parcels, working from the most significant end, and presents one instruction at a time on a second valid/ready interface. An instruction is either one parcel (15 bits) or two parcels (30 bits). The major opcode alone decides which, through a parameter table. A 30-bit instruction never crosses into the next word. When a two-parcel opcode lands in the last parcel of a word, that parcel is treated as filler and the block moves straight to the next word.

Each presented instruction is split into fields:
- the 6-bit major opcode;
- two 3-bit register fields;
- an operand field, which is the low 18 bits of a long instruction or the last 3 bits of a short one;
- the length;
- the parcel position it started at.

Two major opcodes are groups of eight. For these, the first register field also serves as a sub-opcode, and a group flag is raised.

A flush input, raised when a branch is taken, throws away whatever is left of the held word. The word accepted in the flush cycle, or the first one after it, is unpacked from its first parcel. With both sides always ready, the block issues one instruction per clock and fetches the next word without a bubble.

Top module: `parcel_unpacker`

## Requirements
- R1: While reset is held and in the first cycle after it, `insn_valid` is 0 and `word_ready` is 1.
- R2: Instructions leave in word order and, within a word, from bit 59 downward in 15-bit steps (parcel positions 0 to 3, starting at bits 59, 44, 29, 14). `insn_pos` advances by 1 after a short instruction and by 2 after a long one.
- R3: Major opcodes 1 to 7 and 40 to 47 (octal 01-07 and 50-57) are 30 bits long and set `insn_long`. Every other opcode is 15 bits long.
- R4: The instruction's top 6 bits give `insn_op`, the next 3 bits give `insn_i`, and the 3 after that give `insn_j`. For a long instruction, `insn_k` is its low 18 bits. For a short one, `insn_k` is its last 3 bits, zero-extended.
- R5: For opcodes 1 and 23 (octal 01 and 27), `insn_ext` is 1 and `insn_sub` equals the 3 bits after the opcode. For every other opcode, both are 0.
- R6: A long opcode at parcel position 3 is never presented. The rest of that word is dropped, and the next instruction comes from parcel 0 of the next word.
- R7: In a cycle with `flush` high, the held word's remaining parcels are discarded. The next instruction presented comes from parcel 0 of a newly accepted word. An instruction handed over in the flush cycle itself still counts as delivered.
- R8: While `insn_valid` is high, `insn_ready` is low and `flush` is low, all instruction outputs hold their values into the next cycle.
- R9: With `word_valid` and `insn_ready` held high and only short instructions, one instruction is handed over every clock, across word boundaries.
- R10: `word_ready` is low while an instruction waits unaccepted and no flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | A fetched word is offered |
| word_data | input | 60 | Fetched instruction word |
| word_ready | output | 1 | The block takes the offered word this cycle |
| flush | input | 1 | Taken branch: drop the rest of the held word |
| insn_ready | input | 1 | Downstream takes the presented instruction |
| insn_valid | output | 1 | An instruction is presented |
| insn_op | output | 6 | Major opcode |
| insn_ext | output | 1 | Opcode belongs to one of the two eight-way groups |
| insn_sub | output | 3 | Sub-opcode inside the group, else 0 |
| insn_long | output | 1 | 1 for a 30-bit instruction, 0 for 15-bit |
| insn_i | output | 3 | First register field |
| insn_j | output | 3 | Second register field |
| insn_k | output | 18 | Operand: 18-bit constant or zero-extended 3-bit field |
| insn_pos | output | 2 | Parcel position the instruction starts at |

## Verification
On every cycle, the assertions watch the following:
- the parcel position steps by the instruction length;
- a stalled instruction holds steady and keeps the fetch side blocked;
- a flush always lands on parcel 0;
- a long opcode is never shown at the last parcel;
- sub-opcode and operand padding stay zero where they should.

The bench's scenarios cover the rest:
- that the delivered stream matches a packed random mix in order, including through words padded at their end and random flushes;
- that exactly the flushed parcels go missing;
- that delivery reaches one instruction per clock across word boundaries.

// File: rtl/parcel_unpacker.sv
module parcel_unpacker #(
  parameter int PARCEL_W = 15,
  parameter int PARCELS = 4,
  parameter int OP_W = 6,
  parameter int REG_W = 3,
  parameter logic [2**OP_W-1:0] LONG_OPS = 64'h0000_FF00_0000_00FE,
  parameter logic [OP_W-1:0] EXT_OP_A = 6'o01,
  parameter logic [OP_W-1:0] EXT_OP_B = 6'o27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_valid,
  input  logic [PARCEL_W*PARCELS-1:0] word_data,
  output logic word_ready,
  input  logic flush,
  input  logic insn_ready,
  output logic insn_valid,
  output logic [OP_W-1:0] insn_op,
  output logic insn_ext,
  output logic [REG_W-1:0] insn_sub,
  output logic insn_long,
  output logic [REG_W-1:0] insn_i,
  output logic [REG_W-1:0] insn_j,
  output logic [2*PARCEL_W-OP_W-2*REG_W-1:0] insn_k,
  output logic [$clog2(PARCELS)-1:0] insn_pos
);
  localparam int WORD_W = PARCEL_W * PARCELS;
  localparam int LONG_W = 2 * PARCEL_W;
  localparam int K_W = LONG_W - OP_W - 2 * REG_W;
  localparam int POS_W = $clog2(PARCELS);
  localparam int CNT_W = POS_W + 1;

  logic [WORD_W-1:0] wbuf;
  logic have;
  logic [POS_W-1:0] pos;

  logic [WORD_W-1:0] shifted;
  logic [LONG_W-1:0] window;
  logic [CNT_W-1:0] nxt;
  logic pad, fire, ends, drain, load;

  assign shifted = wbuf << (PARCEL_W * int'(pos));
  assign window = shifted[WORD_W-1 -: LONG_W];

  assign insn_op = window[LONG_W-1 -: OP_W];
  assign insn_i = window[LONG_W-OP_W-1 -: REG_W];
  assign insn_j = window[LONG_W-OP_W-REG_W-1 -: REG_W];
  assign insn_long = LONG_OPS[insn_op];
  assign insn_ext = (insn_op == EXT_OP_A) || (insn_op == EXT_OP_B);
  assign insn_sub = insn_ext ? insn_i : '0;
  assign insn_k = insn_long ? window[K_W-1:0]
                            : {{(K_W-REG_W){1'b0}}, window[K_W-1 -: REG_W]};
  assign insn_pos = pos;

  assign pad = have && insn_long && (pos == POS_W'(PARCELS-1));
  assign insn_valid = have && !pad;
  assign fire = insn_valid && insn_ready;
  assign nxt = {1'b0, pos} + (insn_long ? CNT_W'(2) : CNT_W'(1));
  assign ends = nxt >= CNT_W'(PARCELS);
  assign drain = pad || (fire && ends);
  assign word_ready = !have || drain || flush;
  assign load = word_valid && word_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= 1'b0;
      pos <= '0;
      wbuf <= '0;
    end else if (load) begin
      have <= 1'b1;
      pos <= '0;
      wbuf <= word_data;
    end else if (flush || drain) begin
      have <= 1'b0;
      pos <= '0;
    end else if (fire) begin
      pos <= nxt[POS_W-1:0];
    end
  end
endmodule

module parcel_unpacker_chk #(
  parameter int OP_W = 6,
  parameter int REG_W = 3,
  parameter int K_W = 18,
  parameter int POS_W = 2,
  parameter int PARCELS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic word_ready,
  input logic insn_ready,
  input logic insn_valid,
  input logic [OP_W-1:0] insn_op,
  input logic insn_ext,
  input logic [REG_W-1:0] insn_sub,
  input logic insn_long,
  input logic [REG_W-1:0] insn_i,
  input logic [REG_W-1:0] insn_j,
  input logic [K_W-1:0] insn_k,
  input logic [POS_W-1:0] insn_pos
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_ready && !flush && !word_ready
    |=> insn_pos == ($past(insn_pos) + POS_W'($past(insn_long) ? 2 : 1)));

  p_kpad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !insn_long |-> insn_k[K_W-1:REG_W] == '0);

  p_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !insn_ext |-> insn_sub == '0);

  p_no_tail_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid |-> !(insn_long && insn_pos == POS_W'(PARCELS-1)));

  p_flush_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !insn_valid || insn_pos == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !insn_ready && !flush
    |=> insn_valid && $stable(insn_op) && $stable(insn_i) && $stable(insn_j)
        && $stable(insn_k) && $stable(insn_pos));

  p_block_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !insn_ready && !flush |-> !word_ready);
endmodule

bind parcel_unpacker parcel_unpacker_chk #(
  .OP_W(OP_W), .REG_W(REG_W), .K_W(K_W), .POS_W(POS_W), .PARCELS(PARCELS)
) u_chk (.*);

// File: tb/parcel_unpacker_bench.sv
`timescale 1ns/1ps
module parcel_unpacker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [59:0] word_data = '0;
  logic word_ready;
  logic flush = 1'b0;
  logic insn_ready = 1'b0;
  logic insn_valid;
  logic [5:0] insn_op;
  logic insn_ext;
  logic [2:0] insn_sub;
  logic insn_long;
  logic [2:0] insn_i;
  logic [2:0] insn_j;
  logic [17:0] insn_k;
  logic [1:0] insn_pos;

  parcel_unpacker u_parcel_unpacker (.*);

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] w;
    logic [5:0] op;
    logic lng;
    logic [2:0] i;
    logic [2:0] j;
    logic [17:0] k;
  } exp_t;

  exp_t eq[$];
  logic [59:0] wq[$];
  int gen_idx = 0, acc = 0, fires = 0, cyc = 0;
  int checks = 0, fails = 0;
  int gap_pct = 0, stall_pct = 0, flush_pct = 0;
  bit manual = 0, hs_w = 0, done = 0, prev_hold = 0;
  logic [32:0] held;
  int fire_t[$];

  function automatic bit is_long(logic [5:0] op);
    return (op >= 6'd1 && op <= 6'd7) || (op >= 6'd40 && op <= 6'd47);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(inout logic [59:0] w, inout int p, input logic [5:0] op,
                     input logic [2:0] i, input logic [2:0] j, input logic [17:0] k,
                     input bit keep);
    exp_t e;
    if (is_long(op)) begin
      if (p == 3) w[14:0] = {op, i, j, k[17:15]};
      else w[59-15*p -: 30] = {op, i, j, k};
    end else w[59-15*p -: 15] = {op, i, j, k[2:0]};
    if (keep) begin
      e.w = gen_idx; e.op = op; e.lng = is_long(op); e.i = i; e.j = j;
      e.k = is_long(op) ? k : {15'd0, k[2:0]};
      eq.push_back(e);
    end
    p = (p == 3) ? 4 : p + (is_long(op) ? 2 : 1);
  endtask

  function automatic logic [5:0] rand_op(bit lng, int ext_pct);
    logic [5:0] op;
    if ($urandom_range(99) < ext_pct) return lng ? 6'o01 : 6'o27;
    if (lng) begin
      int r = $urandom_range(14);
      return (r < 7) ? 6'(1 + r) : 6'(40 + r - 7);
    end
    do op = 6'($urandom); while (is_long(op));
    return op;
  endfunction

  task automatic rand_word(int long_pct, int ext_pct);
    logic [59:0] w = 60'($urandom) ^ (60'($urandom) << 30);
    int p = 0;
    while (p < 4) begin
      bit lng = $urandom_range(99) < long_pct;
      logic [5:0] op = rand_op(lng, ext_pct);
      put(w, p, op, 3'($urandom), 3'($urandom), 18'($urandom), !(lng && p == 3));
    end
    wq.push_back(w);
    gen_idx++;
  endtask

  task automatic driver();
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (rst_n) begin
        if (hs_w) void'(wq.pop_front());
        if (!(word_valid && !hs_w)) begin
          if (wq.size() > 0 && $urandom_range(99) >= gap_pct) begin
            word_valid = 1'b1; word_data = wq[0];
          end else word_valid = 1'b0;
        end
        if (!manual) begin
          insn_ready = $urandom_range(99) >= stall_pct;
          flush = flush_pct > 0 && $urandom_range(99) < flush_pct;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_hold)
        check(insn_valid && {insn_op, insn_i, insn_j, insn_k} == held[32:0], "R8",
              "stalled instruction changed", {insn_valid, insn_op, insn_i, insn_j, insn_k},
              {1'b1, held});
      prev_hold = insn_valid && !insn_ready && !flush;
      held = {insn_op, insn_i, insn_j, insn_k};
      if (insn_valid) begin
        if (eq.size() == 0) check(0, "R2", "unexpected instruction", insn_op, 0);
        else begin
          exp_t e = eq[0];
          bit ext = (e.op == 6'o01) || (e.op == 6'o27);
          logic [63:0] a = {insn_op, insn_long, insn_ext, insn_sub, insn_i, insn_j, insn_k};
          logic [63:0] x = {e.op, e.lng, ext, ext ? e.i : 3'd0, e.i, e.j, e.k};
          check(a == x, "R2 R3 R4 R5", "instruction fields", a, x);
        end
      end
      if (insn_valid && !insn_ready && !flush)
        check(!word_ready, "R10", "fetch not blocked", word_ready, 0);
      if (insn_valid && insn_ready) begin
        if (eq.size() > 0) void'(eq.pop_front());
        fires++;
        fire_t.push_back(cyc);
      end
      if (flush)
        while (eq.size() > 0 && eq[0].w == acc - 1) void'(eq.pop_front());
      hs_w = word_valid && word_ready;
      if (hs_w) acc++;
    end else hs_w = 0;
  end

  task automatic drain(string req);
    int n = 0;
    while ((wq.size() > 0 || word_valid) && n < 20000) begin @(negedge clk); n++; end
    flush_pct = 0;
    while (eq.size() > 0 && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    check(eq.size() == 0, req, "instructions left undelivered", eq.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    check(0, "R2", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int f0;
    logic [59:0] w;
    int p;
    fork driver(); join_none
    repeat (3) @(negedge clk);
    check(!insn_valid && word_ready, "R1", "state in reset", {insn_valid, word_ready}, 2'b01);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!insn_valid && word_ready, "R1", "state after reset", {insn_valid, word_ready}, 2'b01);

    repeat (30) rand_word(40, 10);
    drain("R2");

    gap_pct = 30; stall_pct = 30;
    repeat (40) rand_word(50, 20);
    drain("R3");

    gap_pct = 0; stall_pct = 0;
    repeat (4) @(negedge clk);
    fire_t.delete();
    repeat (8) rand_word(0, 0);
    drain("R9");
    check(fire_t.size() == 32 && fire_t[31] - fire_t[0] == 31, "R9",
          "cycles spanned by 32 back-to-back issues",
          fire_t.size() == 32 ? fire_t[31] - fire_t[0] : -1, 31);

    f0 = fires;
    w = '0; p = 0;
    put(w, p, 6'o10, 3'd1, 3'd2, 18'd3, 1);
    put(w, p, 6'o27, 3'd5, 3'd6, 18'd7, 1);
    put(w, p, 6'o33, 3'd4, 3'd4, 18'd4, 1);
    put(w, p, 6'o52, 3'd7, 3'd7, 18'h3FFFF, 0);
    wq.push_back(w); gen_idx++;
    w = '0; p = 0;
    put(w, p, 6'o01, 3'd3, 3'd1, 18'h2A5A5, 1);
    put(w, p, 6'o57, 3'd2, 3'd0, 18'h1_0001, 1);
    wq.push_back(w); gen_idx++;
    drain("R6");
    check(fires - f0 == 5, "R6", "instructions from padded pair of words", fires - f0, 5);

    f0 = fires;
    manual = 1; insn_ready = 1'b0;
    repeat (2) rand_word(0, 0);
    do @(negedge clk); while (!insn_valid);
    @(posedge clk); #1 insn_ready = 1'b1;
    @(posedge clk); #1 insn_ready = 1'b0; flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0; insn_ready = 1'b1;
    drain("R7");
    check(fires - f0 == 5, "R7", "issues around a flush", fires - f0, 5);
    manual = 0;

    gap_pct = 20; stall_pct = 20; flush_pct = 8;
    repeat (40) rand_word(45, 15);
    drain("R7");

    finish_run();
  end
endmodule